// File: doc/BRIEF.md
# Parallel Flash Programming Port Decoder

This block is the device-side logic of a microcontroller's parallel programming port. An external programmer drives five mode-select pins and an address split over three fields: eight low bits, six middle bits and a separate top bit. It also drives a data byte, a reset-pin qualifier, an active-low program-store-enable qualifier, a flag that stands for the presence of the high programming voltage, and an active-low program strobe. The block decodes the requested operation. The operations are code byte write, code byte read, setting one of three lock bits, reading the lock bits, and reading fixed signature bytes.

Writes start on the falling edge of the strobe. Each write then times itself to completion, and a ready output stays low for the whole write. A code write and a lock write have separate durations, both given as parameters in clock cycles. The lock bits are sticky. The first blocks further code writes, and the second masks code reads. The code array is a behavioural byte array of `DEPTH` bytes, indexed by the low address bits, and it holds FFh after the system reset.

All pins are plain level signals with no handshake. The programmer does the pacing by polling the ready output. A strobe given while ready is low is dropped.

Top module: `fpm_prog_port`

## Requirements
- R1: No operation takes place unless `rst_pin` is 1 and `psen_n` is 0. A write also needs `vpp_hi` at 1, otherwise `rdy` stays 1 and no state changes.
- R2: `mode[4:0]` selects the operation. The codes are: code write 01111, code read 00011, lock 1 write 11111, lock 2 write 11100, lock 3 write 10110, lock read 11010, signature read 00000.
- R3: The address is {`addr_top`, `addr_mid`, `addr_lo`}, 15 bits. The array uses its low log2(`DEPTH`) bits and reads FFh after `rst_n`.
- R4: A code write stores `din` at the clock edge where `prog_n` is sampled 0 after being sampled 1 at the previous edge. `rdy` is then 0 for exactly `CODE_WR_CYC` cycles.
- R5: A lock write sets its bit at the strobe edge. `rdy` is then 0 for exactly `LOCK_WR_CYC` cycles.
- R6: A strobe given while `rdy` is 0 is ignored. It writes nothing and does not extend the busy time.
- R7: A strobe under an undecoded mode code, or under a read code, does nothing and leaves `rdy` at 1.
- R8: A lock read returns lock bits 1, 2 and 3 on `dout` bits 2, 3 and 4, with every other bit 0.
- R9: A signature read returns 1Eh at address 000h, 87h at 100h, 07h at 200h and 00h at any other address.
- R10: With lock bit 1 set, a code write stores nothing and leaves `rdy` at 1. With lock bit 2 set, a code read returns FFh.
- R11: `dout_oe` is 1 only during a qualified read mode. When it is 0, `dout` is 00h.
- R12: The lock bits stay set until `rst_n` is asserted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| rst_pin | input | 1 | Reset-pin qualifier, must be high |
| psen_n | input | 1 | Program-store-enable qualifier, must be low |
| vpp_hi | input | 1 | High programming voltage present |
| prog_n | input | 1 | Active-low program strobe |
| mode | input | 5 | Mode-select code |
| addr_lo | input | 8 | Address bits 7:0 |
| addr_mid | input | 6 | Address bits 13:8 |
| addr_top | input | 1 | Address bit 14 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data output enable |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
The bench measures the exact length of the low `rdy` pulse for both write classes. An off-by-one timer, or a duration swapped between the classes, therefore shows up as a wrong count. It strikes a second strobe in the middle of a write. A design that restarted the timer would show a longer pulse, and a design that accepted the strobe would corrupt the second address. It also attempts writes without the voltage flag, with a wrong qualifier and under undecoded codes, and it tries a code write after lock bit 1 is set. A design missing any of these gates would pull `rdy` low or change a stored byte. Signature reads at non-signature addresses, lock reads after each lock step, and a system reset at the end catch wrong bit placement and lock bits that do not clear.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_CODE_WR, OP_CODE_RD, OP_LK1_WR,
    OP_LK2_WR, OP_LK3_WR, OP_LK_RD, OP_SIG_RD
  } fpm_op_e;

  localparam logic [4:0] MC_CODE_WR = 5'b01111;
  localparam logic [4:0] MC_CODE_RD = 5'b00011;
  localparam logic [4:0] MC_LK1_WR  = 5'b11111;
  localparam logic [4:0] MC_LK2_WR  = 5'b11100;
  localparam logic [4:0] MC_LK3_WR  = 5'b10110;
  localparam logic [4:0] MC_LK_RD   = 5'b11010;
  localparam logic [4:0] MC_SIG_RD  = 5'b00000;

  localparam int ADDR_W = 15;
endpackage

// File: rtl/fpm_mode_decode.sv
module fpm_mode_decode
  import fpm_pkg::*;
(
  input  logic [4:0] mode,
  input  logic       rst_pin,
  input  logic       psen_n,
  input  logic       vpp_hi,
  output fpm_op_e    op,
  output logic       wr_ok,
  output logic       rd_ok
);
  logic qual;
  logic is_wr;
  logic is_rd;

  always_comb begin
    unique case (mode)
      MC_CODE_WR: op = OP_CODE_WR;
      MC_CODE_RD: op = OP_CODE_RD;
      MC_LK1_WR:  op = OP_LK1_WR;
      MC_LK2_WR:  op = OP_LK2_WR;
      MC_LK3_WR:  op = OP_LK3_WR;
      MC_LK_RD:   op = OP_LK_RD;
      MC_SIG_RD:  op = OP_SIG_RD;
      default:    op = OP_NONE;
    endcase
  end

  assign qual  = rst_pin & ~psen_n;
  assign is_wr = (op == OP_CODE_WR) | (op == OP_LK1_WR) |
                 (op == OP_LK2_WR) | (op == OP_LK3_WR);
  assign is_rd = (op == OP_CODE_RD) | (op == OP_LK_RD) | (op == OP_SIG_RD);
  assign wr_ok = qual & vpp_hi & is_wr;
  assign rd_ok = qual & is_rd;
endmodule

// File: rtl/fpm_busy_timer.sv
module fpm_busy_timer #(
  parameter int CODE_CYC = 50,
  parameter int LOCK_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy
);
  localparam int MAX_CYC = (CODE_CYC > LOCK_CYC) ? CODE_CYC : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= long_sel ? CNT_W'(LOCK_CYC - 1) : CNT_W'(CODE_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fpm_read_mux.sv
module fpm_read_mux
  import fpm_pkg::*;
(
  input  fpm_op_e           op,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mem_byte,
  input  logic [2:0]        lock,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  logic [7:0] sig_byte;

  always_comb begin
    unique case (addr)
      15'h000: sig_byte = 8'h1E;
      15'h100: sig_byte = 8'h87;
      15'h200: sig_byte = 8'h07;
      default: sig_byte = 8'h00;
    endcase
  end

  always_comb begin
    dout = 8'h00;
    if (rd_ok) begin
      unique case (op)
        OP_CODE_RD: dout = lock[1] ? 8'hFF : mem_byte;
        OP_LK_RD:   dout = {3'b000, lock, 2'b00};
        OP_SIG_RD:  dout = sig_byte;
        default:    dout = 8'h00;
      endcase
    end
  end

  assign dout_oe = rd_ok;
endmodule

// File: rtl/fpm_prog_port.sv
module fpm_prog_port
  import fpm_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int CODE_WR_CYC = 50,
  parameter int LOCK_WR_CYC = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin,
  input  logic       psen_n,
  input  logic       vpp_hi,
  input  logic       prog_n,
  input  logic [4:0] mode,
  input  logic [7:0] addr_lo,
  input  logic [5:0] addr_mid,
  input  logic       addr_top,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  output logic       rdy
);
  localparam int IDX_W = $clog2(DEPTH);

  fpm_op_e           op;
  logic              wr_ok, rd_ok;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;
  logic              prog_q;
  logic              busy;
  logic              strobe;
  logic              code_go;
  logic              lock_go;
  logic [2:0]        lock;
  logic [7:0]        mem [DEPTH];

  assign addr = {addr_top, addr_mid, addr_lo};
  assign idx  = addr[IDX_W-1:0];

  fpm_mode_decode u_dec (
    .mode(mode), .rst_pin(rst_pin), .psen_n(psen_n), .vpp_hi(vpp_hi),
    .op(op), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= 1'b1;
    else        prog_q <= prog_n;
  end

  assign strobe  = prog_q & ~prog_n & ~busy & wr_ok;
  assign code_go = strobe & (op == OP_CODE_WR) & ~lock[0];
  assign lock_go = strobe & ((op == OP_LK1_WR) | (op == OP_LK2_WR) |
                             (op == OP_LK3_WR));

  fpm_busy_timer #(.CODE_CYC(CODE_WR_CYC), .LOCK_CYC(LOCK_WR_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(code_go | lock_go),
    .long_sel(lock_go), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 3'b000;
    end else if (lock_go) begin
      if (op == OP_LK1_WR) lock[0] <= 1'b1;
      if (op == OP_LK2_WR) lock[1] <= 1'b1;
      if (op == OP_LK3_WR) lock[2] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (code_go) begin
      mem[idx] <= din;
    end
  end

  fpm_read_mux u_rd (
    .op(op), .rd_ok(rd_ok), .addr(addr), .mem_byte(mem[idx]), .lock(lock),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign rdy = ~busy;
endmodule

// File: rtl/fpm_prog_port_chk.sv
module fpm_prog_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin,
  input logic       psen_n,
  input logic       vpp_hi,
  input logic       prog_n,
  input logic [4:0] mode,
  input logic [7:0] dout,
  input logic       dout_oe,
  input logic       rdy,
  input logic [2:0] lock
);
  // R1: a write may only begin under full qualification and a low strobe
  a_r1_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(rst_pin) && !$past(psen_n) && $past(vpp_hi) && !$past(prog_n));

  // R11: output enable only in read codes
  a_r11_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> rst_pin && !psen_n &&
      (mode == 5'b00011 || mode == 5'b11010 || mode == 5'b00000));

  // R11: idle data value
  a_r11_dout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == 8'h00);

  // R12: lock bits never clear without reset
  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock & $past(lock)) == $past(lock));

  // R10: no code write starts once lock bit 1 is set
  a_r10_lock1_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) && $past(mode) == 5'b01111 |-> !$past(lock[0]));

  // R10: masked code reads
  a_r10_lock2_masks: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe && mode == 5'b00011 && lock[1] |-> dout == 8'hFF);
endmodule

bind fpm_prog_port fpm_prog_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .psen_n(psen_n),
  .vpp_hi(vpp_hi), .prog_n(prog_n), .mode(mode), .dout(dout),
  .dout_oe(dout_oe), .rdy(rdy), .lock(lock)
);

// File: tb/test_fpm_prog_port.sv
module test_fpm_prog_port;
  localparam int CODE_CYC = 50;
  localparam int LOCK_CYC = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_pin = 1'b1, psen_n = 1'b0, vpp_hi = 1'b0, prog_n = 1'b1;
  logic [4:0] mode = 5'b10001;
  logic [7:0] addr_lo = '0;
  logic [5:0] addr_mid = '0;
  logic       addr_top = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe, rdy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpm_prog_port #(.DEPTH(1024), .CODE_WR_CYC(CODE_CYC), .LOCK_WR_CYC(LOCK_CYC))
  i_fpm_prog_port (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .psen_n(psen_n),
    .vpp_hi(vpp_hi), .prog_n(prog_n), .mode(mode), .addr_lo(addr_lo),
    .addr_mid(addr_mid), .addr_top(addr_top), .din(din), .dout(dout),
    .dout_oe(dout_oe), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [14:0] a);
    {addr_top, addr_mid, addr_lo} = a;
  endtask

  task automatic strobe_count(output int n);
    @(negedge clk) prog_n = 1'b0;
    @(negedge clk) prog_n = 1'b1;
    n = 0;
    while (rdy == 1'b0 && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [4:0] m, input logic [14:0] a,
                          input logic [7:0] d, output int n);
    @(negedge clk);
    mode = m; set_addr(a); din = d;
    strobe_count(n);
    mode = 5'b10001;
  endtask

  task automatic do_read(input logic [4:0] m, input logic [14:0] a,
                         output logic [7:0] d, output logic oe);
    @(negedge clk);
    mode = m; set_addr(a);
    @(negedge clk);
    d = dout; oe = dout_oe;
    mode = 5'b10001;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk(rdy == 1'b1, "R4 reset rdy", rdy, 1);
    chk(dout_oe == 1'b0 && dout == 8'h00, "R11 idle output", {dout_oe, dout}, 0);
    do_read(5'b00011, 15'h0000, d, oe);
    chk(oe && d == 8'hFF, "R3 erased after reset", d, 8'hFF);
  endtask

  task automatic t_code_rw;
    logic [7:0] d; logic oe; int n;
    vpp_hi = 1'b1;
    do_write(5'b01111, 15'h02A5, 8'h3C, n);
    chk(n == CODE_CYC, "R4 code write busy length", n, CODE_CYC);
    do_write(5'b01111, 15'h03FF, 8'hC3, n);
    do_read(5'b00011, 15'h02A5, d, oe);
    chk(oe && d == 8'h3C, "R4 R3 readback 2A5", d, 8'h3C);
    do_read(5'b00011, 15'h03FF, d, oe);
    chk(d == 8'hC3, "R3 readback 3FF", d, 8'hC3);
    do_write(5'b01111, 15'h4011, 8'h5A, n);
    do_read(5'b00011, 15'h0011, d, oe);
    chk(d == 8'h5A, "R3 low index bits select byte", d, 8'h5A);
  endtask

  task automatic t_restrike;
    logic [7:0] d; logic oe; int n;
    @(negedge clk);
    mode = 5'b01111; set_addr(15'h0040); din = 8'h11;
    prog_n = 1'b0;
    @(negedge clk) prog_n = 1'b1;
    n = 0;
    while (rdy == 1'b0 && n < 100000) begin
      n++;
      if (n == 10) begin set_addr(15'h0041); din = 8'h22; prog_n = 1'b0; end
      if (n == 11) prog_n = 1'b1;
      @(negedge clk);
    end
    mode = 5'b10001;
    chk(n == CODE_CYC, "R6 busy not extended", n, CODE_CYC);
    do_read(5'b00011, 15'h0041, d, oe);
    chk(d == 8'hFF, "R6 strobe during busy ignored", d, 8'hFF);
    do_read(5'b00011, 15'h0040, d, oe);
    chk(d == 8'h11, "R6 first write kept", d, 8'h11);
  endtask

  task automatic t_qualifiers;
    logic [7:0] d; logic oe; int n;
    vpp_hi = 1'b0;
    do_write(5'b01111, 15'h0050, 8'h77, n);
    chk(n == 0, "R1 no write without vpp", n, 0);
    vpp_hi = 1'b1; psen_n = 1'b1;
    do_write(5'b01111, 15'h0050, 8'h77, n);
    chk(n == 0, "R1 no write with psen_n high", n, 0);
    do_read(5'b00011, 15'h0050, d, oe);
    chk(!oe && d == 8'h00, "R1 R11 no read with psen_n high", {oe, d}, 0);
    psen_n = 1'b0; rst_pin = 1'b0;
    do_write(5'b01111, 15'h0050, 8'h77, n);
    chk(n == 0, "R1 no write with rst_pin low", n, 0);
    rst_pin = 1'b1;
    do_write(5'b10101, 15'h0050, 8'h77, n);
    chk(n == 0, "R7 undecoded code no busy", n, 0);
    do_write(5'b00011, 15'h0050, 8'h77, n);
    chk(n == 0, "R7 read code strobe no busy", n, 0);
    do_read(5'b00011, 15'h0050, d, oe);
    chk(d == 8'hFF, "R1 R7 byte unchanged", d, 8'hFF);
    do_read(5'b01111, 15'h0050, d, oe);
    chk(!oe, "R11 oe low in write mode", oe, 0);
  endtask

  task automatic t_signature;
    logic [7:0] d; logic oe;
    do_read(5'b00000, 15'h0000, d, oe);
    chk(oe && d == 8'h1E, "R9 sig 000", d, 8'h1E);
    do_read(5'b00000, 15'h0100, d, oe);
    chk(d == 8'h87, "R9 sig 100", d, 8'h87);
    do_read(5'b00000, 15'h0200, d, oe);
    chk(d == 8'h07, "R9 sig 200", d, 8'h07);
    do_read(5'b00000, 15'h0300, d, oe);
    chk(d == 8'h00, "R9 sig other", d, 8'h00);
  endtask

  task automatic t_locks;
    logic [7:0] d; logic oe; int n;
    do_read(5'b11010, 15'h0000, d, oe);
    chk(oe && d == 8'h00, "R8 locks clear", d, 0);
    do_write(5'b11111, 15'h0000, 8'h00, n);
    chk(n == LOCK_CYC, "R5 lock write busy length", n, LOCK_CYC);
    do_read(5'b11010, 15'h0000, d, oe);
    chk(d == 8'h04, "R8 R2 lock1 on bit 2", d, 8'h04);
    do_write(5'b01111, 15'h0060, 8'h99, n);
    chk(n == 0, "R10 locked write no busy", n, 0);
    do_read(5'b00011, 15'h0060, d, oe);
    chk(d == 8'hFF, "R10 locked write stores nothing", d, 8'hFF);
    do_read(5'b00011, 15'h02A5, d, oe);
    chk(d == 8'h3C, "R10 read still open", d, 8'h3C);
    do_write(5'b11100, 15'h0000, 8'h00, n);
    chk(n == LOCK_CYC, "R5 lock2 busy length", n, LOCK_CYC);
    do_read(5'b11010, 15'h0000, d, oe);
    chk(d == 8'h0C, "R8 lock2 on bit 3", d, 8'h0C);
    do_read(5'b00011, 15'h02A5, d, oe);
    chk(d == 8'hFF, "R10 lock2 masks read", d, 8'hFF);
    do_write(5'b10110, 15'h0000, 8'h00, n);
    do_read(5'b11010, 15'h0000, d, oe);
    chk(d == 8'h1C, "R8 lock3 on bit 4", d, 8'h1C);
  endtask

  task automatic t_sysreset;
    logic [7:0] d; logic oe;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    do_read(5'b11010, 15'h0000, d, oe);
    chk(d == 8'h00, "R12 locks cleared by reset", d, 0);
    do_read(5'b00011, 15'h02A5, d, oe);
    chk(d == 8'hFF, "R3 array FF after reset", d, 8'hFF);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL all watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_code_rw();
    t_restrike();
    t_qualifiers();
    t_signature();
    t_locks();
    t_sysreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule